// File: doc/BRIEF.md
# CCD Line Region Classifier and Black-Level Estimator

This block sits behind the readout sequencer of a full-frame CCD. The sequencer supplies a 1-based pixel position within the line, a 1-based line position within the frame and a strobe for each digitised sample. The block uses a fixed column and row map to decide what each sample is: a dummy, an internal test pixel, a buffer pixel, a light-shielded dark pixel or a real image pixel. It publishes that decision as a 3-bit region code.

Only the leading shielded columns of a line feed the black-level estimate. Their mean becomes the black level for the rest of that line. Every image sample leaves the block with this level removed, and the result never goes below zero. A second, slower estimate is the mean of the per-line levels over the fully shielded lines at the top of the frame. It is held for the remainder of the frame, so downstream logic can use it as a frame-wide reference.

Both means come from a sum multiplied by a fixed-point reciprocal, because the divisor is not a power of two. Every output is registered exactly once after the sample that produced it.

Top module: `ccd_black_level_top`

## Requirements
- R1: Pixel positions 1 through 11 carry region code 0 (dummy) on every line.
- R2: Positions 12 through 15 and positions 4143 through 4145 carry region code 1 (test). Any position or line outside the frame (position 0 or above 4145, line 0 or above 4128) also carries code 1.
- R3: Region code 3 (dark) is given to positions 16 through 35 and 4134 through 4142 on every line. It is also given to positions 36 through 4133 on lines 1 through 20 and on lines 4120 through 4128.
- R4: Region code 2 (buffer) is given to positions 36 and 4133 on lines 22 through 4118. It is also given to all positions 36 through 4133 on lines 21 and 4119.
- R5: Region code 4 (active) and the active-valid flag apply only to positions 37 through 4132 on lines 22 through 4118. The active-valid flag is raised only when the sample strobe is high.
- R6: The line dark level equals floor(S/20), where S is the sum of the samples at positions 16 through 35 of the current line. It changes only in the cycle after the position-35 sample. Samples at any other position, including the trailing shielded positions, leave it untouched.
- R7: For an active sample, the corrected output equals the sample minus the line dark level, or 0 when the sample is not greater than that level. The corrected output is 0 whenever active-valid is low.
- R8: The frame dark level equals floor(F/20), where F is the sum of the 20 line dark levels produced on lines 1 through 20. It changes only in the cycle after the position-35 sample of line 20 and holds at all other times.
- R9: All outputs follow their sample by one clock. On a cycle without the strobe, the region code holds, and active-valid and the corrected output go to 0.
- R10: During reset, all outputs are 0. The region code therefore reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe: a digitised sample is present |
| sampleIn | input | 16 | Digitised sample |
| pixCount | input | 13 | Pixel position within the line, 1-based |
| lineCount | input | 13 | Line position within the frame, 1-based |
| regionTag | output | 3 | Region code of the last strobed sample |
| activeValid | output | 1 | Corrected output carries an image pixel |
| correctedOut | output | 16 | Image sample minus the line dark level, floored at 0 |
| lineDark | output | 16 | Black level of the current line |
| frameDark | output | 16 | Black level taken from the top shielded lines |

## Verification
The hardest state to reach from the ports is a frame dark level that depends on 20 complete line estimates. In real readout, that needs more than 80,000 samples. Because the bench drives the counters directly, it can feed only positions 16 through 35 on lines 1 through 20. It checks that the frame level is still unchanged after line 19 and correct right after line 20. The bench also checks the floor behaviour of the reciprocal divide, using sums that fall just below a multiple of 20 and sums at full scale.

// File: rtl/ccd_region_pkg.sv
package ccd_region_pkg;

  typedef enum logic [2:0] {
    TAG_DUMMY  = 3'd0,
    TAG_TEST   = 3'd1,
    TAG_BUFFER = 3'd2,
    TAG_DARK   = 3'd3,
    TAG_ACTIVE = 3'd4
  } regionTag_e;

  typedef struct packed {
    regionTag_e tag;
    logic       isActive;
    logic       darkFirst;
    logic       darkAdd;
    logic       darkLast;
    logic       frameFirst;
    logic       frameIn;
    logic       frameLast;
  } ctrlStrobes_t;

endpackage

// File: rtl/ccd_mean_div.sv
module ccd_mean_div #(
  parameter int IN_W  = 21,
  parameter int OUT_W = 16,
  parameter int DIV_N = 20
) (
  input  logic [IN_W-1:0]  sumIn,
  output logic [OUT_W-1:0] meanOut
);
  localparam int SH     = IN_W + $clog2(DIV_N) + 1;
  localparam int PROD_W = IN_W + SH;
  localparam longint unsigned RECIP_L = ((longint'(1) << SH) + longint'(DIV_N) - 1) / longint'(DIV_N);
  localparam logic [SH-1:0] RECIP = SH'(RECIP_L);

  logic [PROD_W-1:0] prod;

  assign prod    = PROD_W'(sumIn) * PROD_W'(RECIP);
  assign meanOut = prod[SH +: OUT_W];

  generate
    if (PROD_W > SH + OUT_W) begin : g_upper
      logic unusedUpperBits;
      assign unusedUpperBits = ^prod[PROD_W-1:SH+OUT_W];
    end
  endgenerate

  logic unusedLowerBits;
  assign unusedLowerBits = ^prod[SH-1:0];
endmodule

// File: rtl/ccd_region_ctrl.sv
module ccd_region_ctrl
  import ccd_region_pkg::*;
#(
  parameter int LINE_PIX        = 4145,
  parameter int FRAME_LINES     = 4128,
  parameter int DUMMY_LAST      = 11,
  parameter int TEST_LEAD_LAST  = 15,
  parameter int DARK_LEAD_LAST  = 35,
  parameter int ACT_FIRST       = 37,
  parameter int ACT_LAST        = 4132,
  parameter int DARK_TRAIL_LAST = 4142,
  parameter int DARK_TOP_LINES  = 20,
  parameter int DARK_BOT_LINES  = 9,
  parameter int CNT_W           = 13,
  parameter int LINE_W          = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  pixCount,
  input  logic [LINE_W-1:0] lineCount,
  output ctrlStrobes_t      strobes
);
  localparam logic [CNT_W-1:0]  C_ONE        = CNT_W'(1);
  localparam logic [CNT_W-1:0]  C_LINE_PIX   = CNT_W'(LINE_PIX);
  localparam logic [CNT_W-1:0]  C_DUMMY_LAST = CNT_W'(DUMMY_LAST);
  localparam logic [CNT_W-1:0]  C_TEST_LAST  = CNT_W'(TEST_LEAD_LAST);
  localparam logic [CNT_W-1:0]  C_DARK_FIRST = CNT_W'(TEST_LEAD_LAST + 1);
  localparam logic [CNT_W-1:0]  C_DARK_LAST  = CNT_W'(DARK_LEAD_LAST);
  localparam logic [CNT_W-1:0]  C_BUF_LEAD   = CNT_W'(ACT_FIRST - 1);
  localparam logic [CNT_W-1:0]  C_BUF_TRAIL  = CNT_W'(ACT_LAST + 1);
  localparam logic [CNT_W-1:0]  C_TRAIL_LAST = CNT_W'(DARK_TRAIL_LAST);
  localparam logic [LINE_W-1:0] L_ONE        = LINE_W'(1);
  localparam logic [LINE_W-1:0] L_FRAME      = LINE_W'(FRAME_LINES);
  localparam logic [LINE_W-1:0] L_TOP_LAST   = LINE_W'(DARK_TOP_LINES);
  localparam logic [LINE_W-1:0] L_IMG_FIRST  = LINE_W'(DARK_TOP_LINES + 1);
  localparam logic [LINE_W-1:0] L_IMG_LAST   = LINE_W'(FRAME_LINES - DARK_BOT_LINES);

  logic pixOk, lineOk, rowDark, rowBuf;

  always_comb begin
    pixOk   = (pixCount >= C_ONE) && (pixCount <= C_LINE_PIX);
    lineOk  = (lineCount >= L_ONE) && (lineCount <= L_FRAME);
    rowDark = (lineCount <= L_TOP_LAST) || (lineCount > L_IMG_LAST);
    rowBuf  = (lineCount == L_IMG_FIRST) || (lineCount == L_IMG_LAST);

    if (!pixOk || !lineOk)               strobes.tag = TAG_TEST;
    else if (pixCount <= C_DUMMY_LAST)   strobes.tag = TAG_DUMMY;
    else if (pixCount <= C_TEST_LAST)    strobes.tag = TAG_TEST;
    else if (pixCount <= C_DARK_LAST)    strobes.tag = TAG_DARK;
    else if (pixCount <= C_BUF_TRAIL) begin
      if (rowDark)                       strobes.tag = TAG_DARK;
      else if (rowBuf || pixCount == C_BUF_LEAD || pixCount == C_BUF_TRAIL)
                                         strobes.tag = TAG_BUFFER;
      else                               strobes.tag = TAG_ACTIVE;
    end
    else if (pixCount <= C_TRAIL_LAST)   strobes.tag = TAG_DARK;
    else                                 strobes.tag = TAG_TEST;

    strobes.isActive   = (strobes.tag == TAG_ACTIVE);
    strobes.darkFirst  = lineOk && (pixCount == C_DARK_FIRST);
    strobes.darkAdd    = lineOk && (pixCount > C_DARK_FIRST) && (pixCount <= C_DARK_LAST);
    strobes.darkLast   = lineOk && (pixCount == C_DARK_LAST);
    strobes.frameIn    = (lineCount >= L_ONE) && (lineCount <= L_TOP_LAST);
    strobes.frameFirst = (lineCount == L_ONE);
    strobes.frameLast  = (lineCount == L_TOP_LAST);
  end

  // R1: dummy columns never reach the dark accumulator
  a_r1_dummy_not_summed: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tag == TAG_DUMMY) |-> !(strobes.darkFirst || strobes.darkAdd));

  // R6: only columns tagged dark feed the estimate
  a_r6_sum_only_dark: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.darkFirst || strobes.darkAdd) |-> (strobes.tag == TAG_DARK));

  // R5: active pixels lie strictly inside the buffer rows
  a_r5_active_rows: assert property (@(posedge clk) disable iff (!rstN)
    strobes.isActive |-> ((lineCount > L_IMG_FIRST) && (lineCount < L_IMG_LAST)));

  // R8: the frame closes on a shielded top line
  a_r8_frame_close_top: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameLast |-> strobes.frameIn);
endmodule

// File: rtl/ccd_dark_datapath.sv
module ccd_dark_datapath
  import ccd_region_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DARK_N = 20,
  parameter int TOP_N  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  ctrlStrobes_t      strobes,
  output regionTag_e        regionTag,
  output logic              activeValid,
  output logic [DATA_W-1:0] correctedOut,
  output logic [DATA_W-1:0] lineDark,
  output logic [DATA_W-1:0] frameDark
);
  localparam int SUM_W  = DATA_W + $clog2(DARK_N);
  localparam int FSUM_W = DATA_W + $clog2(TOP_N);

  logic [SUM_W-1:0]  darkAcc, accNext;
  logic [FSUM_W-1:0] frameAcc, frameNext;
  logic [DATA_W-1:0] meanLine, meanFrame, satDiff;

  assign accNext   = darkAcc + SUM_W'(sampleIn);
  assign frameNext = strobes.frameFirst ? FSUM_W'(meanLine)
                                        : frameAcc + FSUM_W'(meanLine);
  assign satDiff   = (sampleIn > lineDark) ? (sampleIn - lineDark) : '0;

  ccd_mean_div #(.IN_W(SUM_W), .OUT_W(DATA_W), .DIV_N(DARK_N)) u_lineDiv (
    .sumIn(accNext), .meanOut(meanLine));

  ccd_mean_div #(.IN_W(FSUM_W), .OUT_W(DATA_W), .DIV_N(TOP_N)) u_frameDiv (
    .sumIn(frameNext), .meanOut(meanFrame));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionTag    <= TAG_DUMMY;
      activeValid  <= 1'b0;
      correctedOut <= '0;
      lineDark     <= '0;
      frameDark    <= '0;
      darkAcc      <= '0;
      frameAcc     <= '0;
    end else if (sampleValid) begin
      regionTag    <= strobes.tag;
      activeValid  <= strobes.isActive;
      correctedOut <= strobes.isActive ? satDiff : '0;
      if (strobes.darkFirst)    darkAcc <= SUM_W'(sampleIn);
      else if (strobes.darkAdd) darkAcc <= accNext;
      if (strobes.darkLast) begin
        lineDark <= meanLine;
        if (strobes.frameIn)   frameAcc  <= frameNext;
        if (strobes.frameLast) frameDark <= meanFrame;
      end
    end else begin
      activeValid  <= 1'b0;
      correctedOut <= '0;
    end
  end

  a_r9_tag_holds: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(regionTag));

  a_r5_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !activeValid);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !activeValid |-> (correctedOut == '0));

  a_r7_never_above_raw: assert property (@(posedge clk) disable iff (!rstN)
    activeValid |-> (correctedOut <= $past(sampleIn)));

  a_r6_line_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && strobes.darkLast) |=> $stable(lineDark));

  a_r8_frame_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && strobes.darkLast && strobes.frameLast) |=> $stable(frameDark));
endmodule

// File: rtl/ccd_black_level_top.sv
module ccd_black_level_top
  import ccd_region_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int LINE_PIX        = 4145,
  parameter int FRAME_LINES     = 4128,
  parameter int DUMMY_LAST      = 11,
  parameter int TEST_LEAD_LAST  = 15,
  parameter int DARK_LEAD_LAST  = 35,
  parameter int ACT_FIRST       = 37,
  parameter int ACT_LAST        = 4132,
  parameter int DARK_TRAIL_LAST = 4142,
  parameter int DARK_TOP_LINES  = 20,
  parameter int DARK_BOT_LINES  = 9,
  localparam int CNT_W          = $clog2(LINE_PIX + 1),
  localparam int LINE_W         = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [CNT_W-1:0]  pixCount,
  input  logic [LINE_W-1:0] lineCount,
  output logic [2:0]        regionTag,
  output logic              activeValid,
  output logic [DATA_W-1:0] correctedOut,
  output logic [DATA_W-1:0] lineDark,
  output logic [DATA_W-1:0] frameDark
);
  localparam int DARK_N = DARK_LEAD_LAST - TEST_LEAD_LAST;

  ctrlStrobes_t strobes;
  regionTag_e   tagReg;

  ccd_region_ctrl #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES), .DUMMY_LAST(DUMMY_LAST),
    .TEST_LEAD_LAST(TEST_LEAD_LAST), .DARK_LEAD_LAST(DARK_LEAD_LAST),
    .ACT_FIRST(ACT_FIRST), .ACT_LAST(ACT_LAST), .DARK_TRAIL_LAST(DARK_TRAIL_LAST),
    .DARK_TOP_LINES(DARK_TOP_LINES), .DARK_BOT_LINES(DARK_BOT_LINES),
    .CNT_W(CNT_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixCount(pixCount), .lineCount(lineCount),
    .strobes(strobes));

  ccd_dark_datapath #(.DATA_W(DATA_W), .DARK_N(DARK_N), .TOP_N(DARK_TOP_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .strobes(strobes), .regionTag(tagReg), .activeValid(activeValid),
    .correctedOut(correctedOut), .lineDark(lineDark), .frameDark(frameDark));

  assign regionTag = tagReg;
endmodule

// File: tb/ccd_black_level_top_tb.sv
`timescale 1ns/1ps
module ccd_black_level_top_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleValid;
  logic [15:0] sampleIn;
  logic [12:0] pixCount, lineCount;
  logic [2:0]  regionTag;
  logic        activeValid;
  logic [15:0] correctedOut, lineDark, frameDark;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ccd_black_level_top u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .pixCount(pixCount), .lineCount(lineCount), .regionTag(regionTag),
    .activeValid(activeValid), .correctedOut(correctedOut),
    .lineDark(lineDark), .frameDark(frameDark));

  // {line, pixel, sample, expected tag, expected active}
  localparam logic [45:0] VEC [20] = '{
    {13'd100,  13'd1,    16'h1111, 3'd0, 1'b0},
    {13'd100,  13'd11,   16'h2222, 3'd0, 1'b0},
    {13'd100,  13'd12,   16'h3333, 3'd1, 1'b0},
    {13'd100,  13'd15,   16'h4444, 3'd1, 1'b0},
    {13'd100,  13'd4143, 16'h5555, 3'd1, 1'b0},
    {13'd100,  13'd4145, 16'h6666, 3'd1, 1'b0},
    {13'd100,  13'd20,   16'h0077, 3'd3, 1'b0},
    {13'd100,  13'd4134, 16'h0088, 3'd3, 1'b0},
    {13'd100,  13'd4142, 16'h0099, 3'd3, 1'b0},
    {13'd100,  13'd36,   16'h0AAA, 3'd2, 1'b0},
    {13'd100,  13'd4133, 16'h0BBB, 3'd2, 1'b0},
    {13'd100,  13'd37,   16'h0123, 3'd4, 1'b1},
    {13'd100,  13'd4132, 16'hBEEF, 3'd4, 1'b1},
    {13'd21,   13'd500,  16'h0CCC, 3'd2, 1'b0},
    {13'd4119, 13'd37,   16'h0DDD, 3'd2, 1'b0},
    {13'd20,   13'd500,  16'h0EEE, 3'd3, 1'b0},
    {13'd4120, 13'd4132, 16'h0FFF, 3'd3, 1'b0},
    {13'd22,   13'd37,   16'h0001, 3'd4, 1'b1},
    {13'd4118, 13'd4132, 16'hFFFF, 3'd4, 1'b1},
    {13'd5,    13'd36,   16'h1234, 3'd3, 1'b0}
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic v, int line, int pix, int smp);
    sampleValid = v;
    lineCount   = 13'(line);
    pixCount    = 13'(pix);
    sampleIn    = 16'(smp);
    @(negedge clk);
  endtask

  function automatic string tagReq(logic [2:0] t);
    case (t)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int sum;
    int lineMean;
    int frameSum;
    int expLine;
    int expFrame;

    rstN = 1'b0; sampleValid = 1'b0; sampleIn = '0; pixCount = '0; lineCount = '0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "tag", 32'(regionTag), 0);
    check("R10", "active", 32'(activeValid), 0);
    check("R10", "corrected", 32'(correctedOut), 0);
    check("R10", "lineDark", 32'(lineDark), 0);
    check("R10", "frameDark", 32'(frameDark), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Region map table (line dark level is still 0)
    for (int i = 0; i < 20; i++) begin
      logic [45:0] v;
      v = VEC[i];
      drive(1'b1, int'(v[45:33]), int'(v[32:20]), int'(v[19:4]));
      check(tagReq(v[3:1]), "tag", 32'(regionTag), 32'(v[3:1]));
      check("R5", "active", 32'(activeValid), 32'(v[0]));
      check("R7", "corrected", 32'(correctedOut), v[0] ? 32'(v[19:4]) : 0);
    end

    // R2: out-of-frame counts
    drive(1'b1, 100, 0, 5);
    check("R2", "tag pixel 0", 32'(regionTag), 1);
    drive(1'b1, 4129, 500, 5);
    check("R2", "tag line 4129", 32'(regionTag), 1);

    // R9: strobe low holds tag, clears active
    drive(1'b1, 100, 37, 500);
    drive(1'b0, 100, 4133, 9999);
    check("R9", "tag hold", 32'(regionTag), 4);
    check("R9", "active low", 32'(activeValid), 0);
    check("R9", "corrected zero", 32'(correctedOut), 0);

    // R6: line dark mean over positions 16..35
    sum = 0;
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 100, 16 + i, 1000 + 7 * i);
      sum += 1000 + 7 * i;
      if (i == 18) check("R6", "before last dark", 32'(lineDark), 0);
    end
    expLine = sum / 20;
    check("R6", "line mean", 32'(lineDark), 32'(expLine));
    for (int p = 1; p <= 15; p++) drive(1'b1, 100, p, 65535);
    for (int p = 4134; p <= 4145; p++) drive(1'b1, 100, p, 65535);
    drive(1'b1, 100, 36, 65535);
    check("R6", "excluded columns", 32'(lineDark), 32'(expLine));

    // R7: subtraction and floor at zero
    drive(1'b1, 100, 37, 2000);
    check("R7", "sub", 32'(correctedOut), 32'(2000 - expLine));
    drive(1'b1, 100, 38, 1000);
    check("R7", "sat below", 32'(correctedOut), 0);
    drive(1'b1, 100, 39, expLine);
    check("R7", "sat equal", 32'(correctedOut), 0);
    drive(1'b1, 100, 40, expLine + 1);
    check("R7", "one above", 32'(correctedOut), 1);

    // R6: floor of non-exact mean (sum 159 -> 7)
    for (int i = 0; i < 20; i++) drive(1'b1, 101, 16 + i, (i == 19) ? 26 : 7);
    check("R6", "floor mean", 32'(lineDark), 7);

    // R6: full-scale mean
    for (int i = 0; i < 20; i++) drive(1'b1, 102, 16 + i, 65535);
    check("R6", "full scale", 32'(lineDark), 65535);
    drive(1'b1, 102, 37, 65535);
    check("R7", "full scale sub", 32'(correctedOut), 0);
    check("R8", "no frame update on image line", 32'(frameDark), 0);

    // R8: frame level from lines 1..20
    frameSum = 0;
    for (int ln = 1; ln <= 20; ln++) begin
      sum = 0;
      for (int i = 0; i < 20; i++) begin
        drive(1'b1, ln, 16 + i, ln * 100 + i);
        sum += ln * 100 + i;
      end
      lineMean = sum / 20;
      frameSum += lineMean;
      check("R6", "top line mean", 32'(lineDark), 32'(lineMean));
      if (ln == 19) check("R8", "before line 20", 32'(frameDark), 0);
    end
    expFrame = frameSum / 20;
    check("R8", "frame mean", 32'(frameDark), 32'(expFrame));
    for (int i = 0; i < 20; i++) drive(1'b1, 21, 16 + i, 9000);
    check("R8", "frame hold", 32'(frameDark), 32'(expFrame));
    check("R6", "line after frame", 32'(lineDark), 9000);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule